// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital command receiver that sits in front of a two-channel 12-bit converter core. A host writes 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The block oversamples all three wires in its own system clock, finds the edges of the select and serial clock lines there, and assembles the command word with no logic running in the serial clock domain.

Each committed word carries two routing bits, a speed-mode bit and a power-down bit, next to a 12-bit code. The routing bits steer the code into a holding buffer and two output code latches. One routing value writes channel A and, in the same update, moves the buffered code into channel B. A host can therefore stage a new channel B value and then change both outputs at once. The speed and power-down flags are refreshed by every committed word. The two output codes and the two flags are the outputs that the analog core consumes.

Top module: `dacif_cmd_top`

## Requirements
- R1: A falling edge on `sel_n` starts a frame and clears the partial word. While `sel_n` is low, every falling edge of `sclk` shifts `sdi` in, most significant bit first. Edges of `sclk` while `sel_n` is high change nothing.
- R2: The word is laid out as follows: bit 15 is the high routing bit, bit 14 is the speed bit, bit 13 is the power-down bit, bit 12 is the low routing bit, and bits 11..0 are the code.
- R3: Output codes and flags change only when a word is committed. A commit happens once the 16th bit has been shifted in, or on a rise of `sel_n` after 1 to 15 bits.
- R4: Routing value 10 (high bit 1, low bit 0) loads channel A with the code. In the same clock it loads channel B with the buffer content from before that word, and it leaves the buffer unchanged.
- R5: Routing value 01 loads only the buffer. Both output codes keep their values.
- R6: Routing value 00 loads the code into both channel B and the buffer.
- R7: Routing value 11 changes neither output code nor the buffer, but it still updates the two flags.
- R8: Every committed word copies its speed bit to `fast_mode` (1 = fast) and its power-down bit to `power_down` (1 = powered down).
- R9: While `rst_n` is low, both codes, the buffer and both flags are zero.
- R10: A frame ended by a rise of `sel_n` after k bits, with k from 1 to 15, commits those k bits right-aligned, with the upper bits zero.
- R11: After 16 bits, further `sclk` edges in the same frame are ignored, and a frame commits at most once.
- R12: A rise of `sel_n` with no bits shifted commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, asynchronous |
| dac_a_code | output | 12 | Channel A output code |
| dac_b_code | output | 12 | Channel B output code |
| fast_mode | output | 1 | Speed flag, 1 = fast |
| power_down | output | 1 | Power-down flag, 1 = powered down |

## Verification
Two functions meet in a single update when routing value 10 arrives. Channel A takes the new code and channel B takes the buffer in the same clock, so channel B must receive the buffer value from before that word and never the new code. The bench first stages a distinct value in the buffer, including a value left there by a short, select-terminated frame. It then sends a 10 word and requires channel A to hold the new code and channel B the staged one. A clocked property in the latch bank also compares channel B with the buffer value of the previous cycle.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   localparam int CTRL_W = 4;

   typedef enum logic [1:0] {
      RT_B_AND_BUF = 2'b00,
      RT_BUF_ONLY  = 2'b01,
      RT_A_XFER_B  = 2'b10,
      RT_RESERVED  = 2'b11
   } route_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int                N       = 3,
   parameter int                STAGES  = 2,
   parameter logic [N-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{RST_VAL[g]}};
         end else begin
            chain <= {chain[STAGES-2:0], din[g]};
         end
      end

      assign dout[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_n_s,
   input  logic               sclk_s,
   input  logic               sdi_s,
   output logic               commit,
   output logic [FRAME_W-1:0] word
);

   localparam int          CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

   logic               sel_d;
   logic               sclk_d;
   logic               active;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] sreg;

   logic sel_fall;
   logic sel_rise;
   logic sclk_fall;

   assign sel_fall  = sel_d & ~sel_n_s;
   assign sel_rise  = ~sel_d & sel_n_s;
   assign sclk_fall = sclk_d & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_d  <= 1'b1;
         sclk_d <= 1'b1;
         active <= 1'b0;
         cnt    <= '0;
         sreg   <= '0;
         commit <= 1'b0;
      end else begin
         sel_d  <= sel_n_s;
         sclk_d <= sclk_s;
         commit <= 1'b0;
         if (sel_fall) begin
            active <= 1'b1;
            cnt    <= '0;
            sreg   <= '0;
         end else if (sel_rise) begin
            active <= 1'b0;
            if (active && (cnt != '0) && (cnt != CNT_FULL)) begin
               commit <= 1'b1;
            end
         end else if (active && sclk_fall && (cnt != CNT_FULL)) begin
            sreg <= {sreg[FRAME_W-2:0], sdi_s};
            cnt  <= cnt + 1'b1;
            if (cnt == CNT_LAST) begin
               commit <= 1'b1;
            end
         end
      end
   end

   assign word = sreg;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL) else $error("bit count past frame"); // R11

   AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit) else $error("commit held two cycles"); // R11

   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_FULL && !sel_fall) |=> $stable(sreg)) else $error("full word changed"); // R11

   AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !sel_fall) |=> $stable(sreg)) else $error("shift outside frame"); // R1

endmodule

// File: rtl/dacif_latch_bank.sv
module dacif_latch_bank #(
   parameter int CODE_W = 12
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 commit,
   input  logic [CODE_W+dacif_pkg::CTRL_W-1:0]  word,
   output logic [CODE_W-1:0]                    dac_a_code,
   output logic [CODE_W-1:0]                    dac_b_code,
   output logic                                 fast_mode,
   output logic                                 power_down
);

   import dacif_pkg::*;

   localparam int FRAME_W = CODE_W + CTRL_W;
   localparam int POS_RH  = FRAME_W - 1;
   localparam int POS_SPD = FRAME_W - 2;
   localparam int POS_PD  = FRAME_W - 3;
   localparam int POS_RL  = FRAME_W - 4;

   route_e              route;
   logic [CODE_W-1:0]   code;
   logic [CODE_W-1:0]   buf_q;

   assign route = route_e'({word[POS_RH], word[POS_RL]});
   assign code  = word[CODE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_a_code <= '0;
         dac_b_code <= '0;
         buf_q      <= '0;
         fast_mode  <= 1'b0;
         power_down <= 1'b0;
      end else if (commit) begin
         fast_mode  <= word[POS_SPD];
         power_down <= word[POS_PD];
         case (route)
            RT_B_AND_BUF: begin
               dac_b_code <= code;
               buf_q      <= code;
            end
            RT_BUF_ONLY: begin
               buf_q <= code;
            end
            RT_A_XFER_B: begin
               dac_a_code <= code;
               dac_b_code <= buf_q;
            end
            default: begin
            end
         endcase
      end
   end

   AST_XFER_OLD_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && route == RT_A_XFER_B) |=> (dac_b_code == $past(buf_q) && $stable(buf_q)))
      else $error("channel B not loaded from prior buffer"); // R4

   AST_BUF_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && route == RT_BUF_ONLY) |=> ($stable(dac_a_code) && $stable(dac_b_code)))
      else $error("buffer-only word moved an output"); // R5

   AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && route == RT_RESERVED) |=> ($stable(dac_a_code) && $stable(dac_b_code) && $stable(buf_q)))
      else $error("reserved word moved a latch"); // R7

   AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(dac_a_code) && $stable(dac_b_code) && $stable(fast_mode) && $stable(power_down)))
      else $error("outputs changed without commit"); // R3

endmodule

// File: rtl/dacif_cmd_top.sv
module dacif_cmd_top #(
   parameter int CODE_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic [CODE_W-1:0] dac_a_code,
   output logic [CODE_W-1:0] dac_b_code,
   output logic              fast_mode,
   output logic              power_down
);

   localparam int FRAME_W = CODE_W + dacif_pkg::CTRL_W;

   if (CODE_W < 2) begin : g_bad_code_w
      $error("CODE_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]         pins_s;
   logic               commit;
   logic [FRAME_W-1:0] word;

   dacif_sync #(
      .N       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({sel_n, sclk, sdi}),
      .dout  (pins_s)
   );

   dacif_shifter #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n_s (pins_s[2]),
      .sclk_s  (pins_s[1]),
      .sdi_s   (pins_s[0]),
      .commit  (commit),
      .word    (word)
   );

   dacif_latch_bank #(
      .CODE_W (CODE_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .word       (word),
      .dac_a_code (dac_a_code),
      .dac_b_code (dac_b_code),
      .fast_mode  (fast_mode),
      .power_down (power_down)
   );

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (dac_a_code == '0 && dac_b_code == '0 && !fast_mode && !power_down))
      else $error("outputs not clear in reset"); // R9

endmodule

// File: tb/dacif_cmd_top_tb.sv
`timescale 1ns/1ps
module dacif_cmd_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        sclk = 1'b1;
   logic        sdi = 1'b0;
   logic [11:0] dac_a_code;
   logic [11:0] dac_b_code;
   logic        fast_mode;
   logic        power_down;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   dacif_cmd_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_n      (sel_n),
      .sclk       (sclk),
      .sdi        (sdi),
      .dac_a_code (dac_a_code),
      .dac_b_code (dac_b_code),
      .fast_mode  (fast_mode),
      .power_down (power_down)
   );

   // {word, expected A, expected B, expected fast, expected power-down}
   localparam logic [41:0] VEC [0:8] = '{
      {16'h0123, 12'h000, 12'h123, 1'b0, 1'b0},
      {16'h1456, 12'h000, 12'h123, 1'b0, 1'b0},
      {16'h8789, 12'h789, 12'h456, 1'b0, 1'b0},
      {16'h4ABC, 12'h789, 12'hABC, 1'b1, 1'b0},
      {16'h3DEF, 12'h789, 12'hABC, 1'b0, 1'b1},
      {16'h9FFF, 12'h789, 12'hABC, 1'b0, 1'b0},
      {16'hE000, 12'h000, 12'hDEF, 1'b1, 1'b1},
      {16'h5111, 12'h000, 12'hDEF, 1'b1, 1'b0},
      {16'hC222, 12'h222, 12'h111, 1'b1, 1'b0}
   };

   function automatic logic [25:0] outs();
      return {dac_a_code, dac_b_code, fast_mode, power_down};
   endfunction

   task automatic check(input string req, input logic [25:0] exp_v);
      @(negedge clk);
      total++;
      if (outs() !== exp_v) begin
         bad++;
         $display("FAIL %s: actual A=%h B=%h f=%b p=%b expected A=%h B=%h f=%b p=%b",
                  req, outs()[25:14], outs()[13:2], outs()[1], outs()[0],
                  exp_v[25:14], exp_v[13:2], exp_v[1], exp_v[0]);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_open();
      sel_n = 1'b0;
      wait_clk(6);
   endtask

   task automatic shift_bit(input logic b);
      sdi = b;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
   endtask

   task automatic frame_close();
      wait_clk(4);
      sel_n = 1'b1;
      wait_clk(12);
   endtask

   task automatic send_bits(input logic [31:0] w, input int n);
      frame_open();
      for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
      frame_close();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [25:0] cur;
      wait_clk(5);
      check("R9 in reset", 26'h0);
      rst_n = 1'b1;
      wait_clk(5);
      check("R9 after reset", 26'h0);

      // R1: serial clock toggling with select high
      for (int i = 0; i < 16; i++) shift_bit(1'b1);
      wait_clk(6);
      check("R1 sclk ignored while idle", 26'h0);

      // table: R2 R4 R5 R6 R7 R8
      for (int k = 0; k < 9; k++) begin
         send_bits({16'h0, VEC[k][41:26]}, 16);
         check($sformatf("R2 R4 R5 R6 R7 R8 table row %0d", k), VEC[k][25:0]);
      end

      // R3: no change in the middle of a frame
      cur = outs();
      frame_open();
      for (int i = 15; i >= 4; i--) shift_bit(logic'(16'h0777 >> i));
      check("R3 mid-frame hold", cur);
      for (int i = 3; i >= 0; i--) shift_bit(logic'(16'h0777 >> i));
      wait_clk(6);
      check("R3 commit at 16th bit before select rise", {12'h222, 12'h777, 1'b0, 1'b0});
      frame_close();

      // R11: extra bits after 16 are ignored
      send_bits({12'h0, 16'h0AAA, 4'hF}, 20);
      check("R11 overlong frame", {12'h222, 12'hAAA, 1'b0, 1'b0});

      // stage buffer with fast flag set
      send_bits({16'h0, 16'h5333}, 16);
      check("R5 buffer-only with fast", {12'h222, 12'hAAA, 1'b1, 1'b0});

      // R12: select pulse with no bits
      sel_n = 1'b0;
      wait_clk(8);
      sel_n = 1'b1;
      wait_clk(12);
      check("R12 empty frame no commit", {12'h222, 12'hAAA, 1'b1, 1'b0});

      // R10: short frame of 8 bits -> word 0x00A5, route 00
      send_bits(32'hA5, 8);
      check("R10 short frame", {12'h222, 12'h0A5, 1'b0, 1'b0});

      // R4: transfer uses buffer written by the short frame
      send_bits({16'h0, 16'h8444}, 16);
      check("R4 transfer after short frame", {12'h444, 12'h0A5, 1'b0, 1'b0});

      // R4: buffer unchanged by the transfer word
      send_bits({16'h0, 16'h8555}, 16);
      check("R4 buffer kept after transfer", {12'h555, 12'h0A5, 1'b0, 1'b0});

      // R9: reset in mid-run
      rst_n = 1'b0;
      wait_clk(3);
      check("R9 reset mid-run", 26'h0);
      rst_n = 1'b1;
      wait_clk(5);
      send_bits({16'h0, 16'h8001}, 16);
      check("R9 buffer cleared by reset", {12'h001, 12'h000, 1'b0, 1'b0});

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule